// File: doc/BRIEF.md
# Fixed-Time Intersection Light Sequencer

This block drives the signal lamps at a crossing of two roads, one running north-south and one running east-west. It has no sensor or request inputs. A single free-running phase counter steps through ten states, one per clock. Each road's red, yellow and green lamp lines are decoded from that counter with plain gate logic. No lookup memory is used.

Each road sees the same four-green, one-yellow, five-red pattern. The north-south pattern is shifted five states from the east-west one, so that whichever road is not red, the other road is. A synchronous active-high reset restarts the cycle at the state where east-west has green. If the phase counter ever holds a value outside the ten legal states, it falls back to state 0 on the next clock.

Top module: `intersection_sequencer`

## Requirements
- R1: On every clock edge with reset low, the phase advances by exactly one state; clock and reset are the only inputs.
- R2: The phase takes the ten values 0 through 9 and wraps from 9 to 0. Any value above 9 returns to 0 on the next clock, so only the ten legal lamp patterns ever appear.
- R3: In phases 0, 1, 2 and 3, east-west shows green and north-south shows red. In phase 4, east-west shows yellow and north-south shows red.
- R4: In phases 5, 6, 7 and 8, north-south shows green and east-west shows red. In phase 9, north-south shows yellow and east-west shows red.
- R5: In every ten-cycle period, each road is green for 4 cycles, yellow for 1 cycle and red for 5 cycles.
- R6: For each road, exactly one of its three lamp lines is high in every cycle.
- R7: Whenever either road shows yellow or green, the other road shows red.
- R8: Reset is synchronous and active high. A clock edge with reset high puts the phase at 0 (east-west green, north-south red), and the phase stays at 0 while reset is held. Raising reset between edges does not change the lamps until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the phase advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset to phase 0 |
| ew_red | output | 1 | East-west red lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_green | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_green | output | 1 | North-south green lamp |

## Verification
The assertions watch the following properties on every cycle:
- the single-step advance of the phase, the 9-to-0 wrap and the recovery from an illegal phase;
- one lamp per road;
- the cross-road red rule;
- the state after a reset edge.

Other properties only the bench's scenarios can show:
- which colour belongs to which phase;
- the 4/1/5 split counted over whole periods;
- a reset raised between edges leaving the lamps unchanged until the next edge, and a clean restart after a reset in mid-cycle.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int unsigned CYCLE_STATES = 10;
    localparam int unsigned GREEN_SPAN   = 4;
    localparam int unsigned YELLOW_SPAN  = 1;
    localparam int unsigned ROAD_COUNT   = 2;

    typedef enum logic [1:0] {
        LAMP_RED    = 2'd0,
        LAMP_YELLOW = 2'd1,
        LAMP_GREEN  = 2'd2
    } lamp_e;

    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } lamp_lines_t;

    // Colour of a road at a given position inside its own period.
    function automatic lamp_e colour_at(input int unsigned pos,
                                        input int unsigned green_len,
                                        input int unsigned yellow_len);
        if (pos < green_len)
            return LAMP_GREEN;
        else if (pos < green_len + yellow_len)
            return LAMP_YELLOW;
        else
            return LAMP_RED;
    endfunction

    // One-hot lamp lines for a colour.
    function automatic lamp_lines_t lines_of(input lamp_e c);
        lamp_lines_t l;
        l.red    = (c == LAMP_RED);
        l.yellow = (c == LAMP_YELLOW);
        l.green  = (c == LAMP_GREEN);
        return l;
    endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int unsigned PERIOD = tlc_pkg::CYCLE_STATES,
    localparam int unsigned W     = $clog2(PERIOD)
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] phase_q;
    logic [W-1:0] phase_d;

    // Next state: step, wrap at the last legal value, and fold any
    // illegal value back to zero.
    always_comb begin
        if (phase_q >= LAST)
            phase_d = '0;
        else
            phase_d = phase_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= phase_d;
    end

    assign phase = phase_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase_q < LAST) |=> (phase_q == $past(phase_q) + W'(1)));  // R1
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST) |=> (phase_q == '0));  // R2
    AST_PHASE_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (phase_q > LAST) |=> (phase_q == '0));  // R2
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (phase_q == '0));  // R8

endmodule

// File: rtl/road_decoder.sv
module road_decoder
    import tlc_pkg::*;
#(
    parameter int unsigned PERIOD     = CYCLE_STATES,
    parameter int unsigned GREEN_LEN  = GREEN_SPAN,
    parameter int unsigned YELLOW_LEN = YELLOW_SPAN,
    parameter int unsigned OFFSET     = 0,
    localparam int unsigned W         = $clog2(PERIOD)
) (
    input  logic [W-1:0] phase,
    output lamp_lines_t  lamps
);
    localparam logic [W:0] PERIOD_V = (W+1)'(PERIOD);
    localparam logic [W:0] OFFSET_V = (W+1)'(OFFSET % PERIOD);

    logic [W:0] shifted;
    logic [W:0] local_pos;
    lamp_e      colour;

    // Position of this road inside its own period, computed without a divider.
    always_comb begin
        shifted = {1'b0, phase} + OFFSET_V;
        if (shifted >= PERIOD_V)
            local_pos = shifted - PERIOD_V;
        else
            local_pos = shifted;
    end

    always_comb begin
        colour = colour_at(int'(local_pos), GREEN_LEN, YELLOW_LEN);
        lamps  = lines_of(colour);
    end

    AST_LAMP_ONEHOT: assert final ($countones(lamps) == 1);  // R6

endmodule

// File: rtl/intersection_sequencer.sv
module intersection_sequencer
    import tlc_pkg::*;
#(
    parameter int unsigned PERIOD     = CYCLE_STATES,
    parameter int unsigned GREEN_LEN  = GREEN_SPAN,
    parameter int unsigned YELLOW_LEN = YELLOW_SPAN
) (
    input  logic clk,
    input  logic rst,
    output logic ew_red,
    output logic ew_yellow,
    output logic ew_green,
    output logic ns_red,
    output logic ns_yellow,
    output logic ns_green
);
    localparam int unsigned W           = $clog2(PERIOD);
    localparam int unsigned HALF_PERIOD = PERIOD / 2;

    logic [W-1:0] phase;
    lamp_lines_t  road_lamps [ROAD_COUNT];

    phase_counter #(.PERIOD(PERIOD)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    // Road 0 is east-west, road 1 is north-south, shifted half a period.
    for (genvar r = 0; r < ROAD_COUNT; r++) begin : g_road
        road_decoder #(
            .PERIOD     (PERIOD),
            .GREEN_LEN  (GREEN_LEN),
            .YELLOW_LEN (YELLOW_LEN),
            .OFFSET     (r * HALF_PERIOD)
        ) u_dec (
            .phase (phase),
            .lamps (road_lamps[r])
        );
    end

    assign ew_red    = road_lamps[0].red;
    assign ew_yellow = road_lamps[0].yellow;
    assign ew_green  = road_lamps[0].green;
    assign ns_red    = road_lamps[1].red;
    assign ns_yellow = road_lamps[1].yellow;
    assign ns_green  = road_lamps[1].green;

    AST_EW_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
        $countones({ew_red, ew_yellow, ew_green}) == 1);  // R6
    AST_NS_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_red, ns_yellow, ns_green}) == 1);  // R6
    AST_EW_GO_NS_RED: assert property (@(posedge clk) disable iff (rst)
        (ew_green || ew_yellow) |-> ns_red);  // R7
    AST_NS_GO_EW_RED: assert property (@(posedge clk) disable iff (rst)
        (ns_green || ns_yellow) |-> ew_red);  // R7
    AST_RESET_EW_GREEN: assert property (@(posedge clk)
        rst |=> (ew_green && ns_red));  // R8
    AST_YELLOW_TO_NS: assert property (@(posedge clk) disable iff (rst)
        ew_yellow |=> ns_green);  // R3
    AST_YELLOW_TO_EW: assert property (@(posedge clk) disable iff (rst)
        ns_yellow |=> ew_green);  // R4

endmodule

// File: tb/tb_intersection_sequencer.sv
`timescale 1ns/1ps
module tb_intersection_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned idx = 0;   // expected phase
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    intersection_sequencer dut (
        .clk       (clk),
        .rst       (rst),
        .ew_red    (ew_red),
        .ew_yellow (ew_yellow),
        .ew_green  (ew_green),
        .ns_red    (ns_red),
        .ns_yellow (ns_yellow),
        .ns_green  (ns_green)
    );

    // Expected lamps {ew r,y,g, ns r,y,g} for a phase, from R3/R4.
    function automatic logic [5:0] expected(input int unsigned p);
        logic [2:0] ew, ns;
        if (p < 4)       ew = 3'b001;
        else if (p == 4) ew = 3'b010;
        else             ew = 3'b100;
        if (p >= 5 && p < 9) ns = 3'b001;
        else if (p == 9)     ns = 3'b010;
        else                 ns = 3'b100;
        return {ew, ns};
    endfunction

    function automatic logic [5:0] observed();
        return {ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h (phase %0d)", req, got, exp, idx);
        end
    endtask

    task automatic test_reset_state();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state", observed(), expected(0));
        idx = 0;
        rst = 1'b0;
    endtask

    // R1, R2, R3, R4, R5, R6, R7: step through whole periods.
    task automatic test_periods(input int unsigned periods);
        for (int unsigned p = 0; p < periods; p++) begin
            int unsigned ew_g = 0, ew_y = 0, ew_r = 0, ns_g = 0, ns_y = 0, ns_r = 0;
            for (int unsigned c = 0; c < 10; c++) begin
                @(negedge clk);
                idx = (idx + 1) % 10;
                if (idx < 5) check("R3 phase pattern", observed(), expected(idx));
                else         check("R4 phase pattern", observed(), expected(idx));
                check("R6 one lamp ew", $countones({ew_red, ew_yellow, ew_green}), 1);
                check("R6 one lamp ns", $countones({ns_red, ns_yellow, ns_green}), 1);
                check("R7 cross red", ((!ew_red) && (!ns_red)) ? 1 : 0, 0);
                ew_g += ew_green; ew_y += ew_yellow; ew_r += ew_red;
                ns_g += ns_green; ns_y += ns_yellow; ns_r += ns_red;
            end
            check("R5 ew green count", ew_g, 4);
            check("R5 ew yellow count", ew_y, 1);
            check("R5 ew red count", ew_r, 5);
            check("R5 ns green count", ns_g, 4);
            check("R5 ns yellow count", ns_y, 1);
            check("R5 ns red count", ns_r, 5);
        end
    endtask

    // R2: the wrap from phase 9 back to 0 and then to 1.
    task automatic test_wrap();
        while (idx != 9) begin
            @(negedge clk);
            idx = (idx + 1) % 10;
        end
        check("R2 at phase 9", observed(), expected(9));
        @(negedge clk); idx = 0;
        check("R2 wrap to 0", observed(), expected(0));
        @(negedge clk); idx = 1;
        check("R1 step after wrap", observed(), expected(1));
    endtask

    // R8: a reset raised between edges takes effect at the next edge only.
    task automatic test_mid_reset();
        while (idx != 6) begin
            @(negedge clk);
            idx = (idx + 1) % 10;
        end
        rst = 1'b1;
        #0.5;
        check("R8 sync no early effect", observed(), expected(6));
        @(negedge clk); idx = 0;
        check("R8 reset to 0", observed(), expected(0));
        @(negedge clk);
        check("R8 held reset stays 0", observed(), expected(0));
        rst = 1'b0;
        @(negedge clk); idx = 1;
        check("R8 restart phase 1", observed(), expected(1));
    endtask

    initial begin
        test_reset_state();
        test_periods(3);
        test_wrap();
        test_mid_reset();
        test_periods(2);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule